// File: doc/BRIEF.md
# Fixed-Frame Serial Receiver with CRC and Sequence Tracking

This block sits behind a serial byte receiver and turns a raw byte stream into checked frames. Every frame has the same length of 272 bytes. The block hunts for a start marker of four 0xAA bytes. It then steps through the header fields and the 256-byte data area, storing the data area in a local buffer. At the end it compares a CRC-32 that it computed itself with the CRC carried in the frame.

Each finished frame produces a one-cycle verdict: good, CRC error or malformed. Only good frames are passed to a sequence tracker. The tracker reports how many frames went missing between two good frames. It also reports a probable restart of the sender when the sequence number falls back to zero. After every frame, whatever the verdict, the receiver goes back to hunting for the next start marker. The stored data of the latest frame can be read through a combinational read port until the next frame writes over it.

Top module: `frx_frame_rx`

## Requirements
- R1: While reset is held and after it is released, `frame_done`, `frame_good`, `frame_crc_err`, `frame_malformed`, `peer_reset`, `lost_count` and `frame_seq` are all zero, and the receiver is hunting.
- R2: A frame starts only after four consecutive accepted bytes equal to 0xAA. Any other byte seen while hunting restarts the count and produces no verdict.
- R3: Byte offsets are counted from the first marker byte. Offsets 4..7 hold the sequence number, 8..9 the version, 10..11 the length, 12..267 the data and 268..271 the CRC. All multi-byte fields are little-endian. `frame_seq` and `frame_len` show the fields of the last finished frame.
- R4: The CRC-32 uses the polynomial 0x04C11DB7 and starts at 0xFFFFFFFF. It is fed MSB-first, with no reflection and no final XOR. It covers the sequence bytes, the length bytes and all 256 data bytes in stream order. A mismatch gives `frame_crc_err`.
- R5: `frame_done` is high for exactly one cycle, in the cycle after the final CRC byte is accepted. In that cycle exactly one of `frame_good`, `frame_crc_err` and `frame_malformed` is high. All four are low in every other cycle.
- R6: Version 0x0001 marks a data frame and version 0x0002 marks a ping frame. `frame_is_ping` is high when the last finished frame carried version 0x0002.
- R7: A frame whose CRC matches but whose version is neither 0x0001 nor 0x0002, or whose length is above 256, is reported as `frame_malformed` and not as good.
- R8: After a verdict, `rd_data` shows the data byte at offset `rd_addr` of the data area, combinationally. Bytes of the data area that lie beyond the stated length hold what was sent.
- R9: The first good frame after reset only sets the sequence baseline. It reports `lost_count` 0 and no `peer_reset`.
- R10: If a good frame's sequence number exceeds the baseline by more than 1, `lost_count` equals the difference minus 1 in the `frame_done` cycle. Otherwise it is 0.
- R11: If a good frame's sequence number is 0 and the baseline is nonzero, `peer_reset` is high in the `frame_done` cycle and `lost_count` is 0.
- R12: `in_valid` low stalls the receiver without losing its place. After any verdict, including a CRC error or a malformed frame, the receiver resynchronises on the next marker.
- R13: A frame with a CRC error or a malformed frame leaves the sequence baseline unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | `in_data` carries a byte this cycle |
| in_data | input | 8 | Received byte |
| frame_done | output | 1 | One-cycle verdict strobe |
| frame_good | output | 1 | Verdict: frame is good |
| frame_crc_err | output | 1 | Verdict: CRC mismatch |
| frame_malformed | output | 1 | Verdict: CRC matches but version or length is illegal |
| frame_is_ping | output | 1 | Last finished frame carried the ping version |
| frame_seq | output | 32 | Sequence number of the last finished frame |
| frame_len | output | 16 | Length field of the last finished frame |
| lost_count | output | 32 | Frames missing before this good frame (valid with `frame_done`) |
| peer_reset | output | 1 | Sequence fell back to zero (valid with `frame_done`) |
| rd_addr | input | 8 | Data-area read address |
| rd_data | output | 8 | Data-area byte at `rd_addr` |

## Verification
Every verdict, together with `lost_count` and `peer_reset`, is due exactly one cycle after the clock edge that takes in the last CRC byte. The bench drives bytes on falling edges. After the last byte it waits exactly one falling edge and samples all results there. It then samples `frame_done` again one cycle later to confirm that the strobe is a single pulse. The read port has no latency, so the data area is checked after the verdict with the input idle. Sequence gaps from 0 to 4 are swept, and the bench predicts each loss count from the sequence values it sent.

// File: rtl/frx_pkg.sv
// Package: shared constants and the CRC-32 byte step for the fixed-frame receiver.
// Assumes byte-serial input; the CRC step is MSB-first with no reflection.
package frx_pkg;
    localparam logic [7:0]  MARK_BYTE = 8'hAA;
    localparam int          MARK_LEN  = 4;
    localparam logic [15:0] VER_DATA  = 16'h0001;
    localparam logic [15:0] VER_PING  = 16'h0002;
    localparam logic [31:0] CRC_POLY  = 32'h04C11DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFFFFFF;

    typedef enum logic {ST_HUNT, ST_BODY} rx_state_t;

    // Advance a CRC-32 register by one byte, most significant bit first.
    function automatic logic [31:0] crc32_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[31] ^ b[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
            else              r = {r[30:0], 1'b0};
        end
        return r;
    endfunction
endpackage

// File: rtl/frx_crc32.sv
// Module: running CRC-32 register. Reloads the seed on clear, folds in one byte on feed.
// Assumes clear and feed are never high together.
module frx_crc32
    import frx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        feed,
    input  logic [7:0]  data,
    output logic [31:0] crc
);
    // Seed on reset or clear, otherwise accumulate fed bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc <= CRC_SEED;
        else if (feed)       crc <= crc32_step(crc, data);
    end
endmodule

// File: rtl/frx_payload_buf.sv
// Module: data-area store. One write port from the receiver, one combinational read port.
// Assumes the reader uses it between frames; the contents are not reset.
module frx_payload_buf #(
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    // Store one data byte per accepted data-area position.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the addressed byte without latency.
    always_comb rdata = mem[raddr];
endmodule

// File: rtl/frx_seq_track.sv
// Module: sequence tracker for good frames. Sets the baseline on the first one,
// then reports counted gaps or a fall back to zero as a peer restart.
// Assumes upd is a single-cycle strobe per good frame.
module frx_seq_track #(
    parameter int SEQ_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [SEQ_W-1:0] seq_in,
    output logic [SEQ_W-1:0] lost_count,
    output logic             peer_reset
);
    logic             have_base;
    logic [SEQ_W-1:0] last_seq;
    logic [SEQ_W:0]   next_exp;

    always_comb next_exp = {1'b0, last_seq} + {{SEQ_W{1'b0}}, 1'b1};

    // Classify each good frame against the baseline and move the baseline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_base  <= 1'b0;
            last_seq   <= '0;
            lost_count <= '0;
            peer_reset <= 1'b0;
        end else begin
            lost_count <= '0;
            peer_reset <= 1'b0;
            if (upd) begin
                have_base <= 1'b1;
                last_seq  <= seq_in;
                if (have_base) begin
                    if (seq_in == '0 && last_seq != '0)
                        peer_reset <= 1'b1;
                    else if ({1'b0, seq_in} > next_exp)
                        lost_count <= seq_in - last_seq - {{(SEQ_W-1){1'b0}}, 1'b1};
                end
            end
        end
    end

    AST_RESET_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        peer_reset |-> lost_count == '0); // R11
    AST_ONE_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_reset || lost_count != '0) |-> $past(upd)); // R10
endmodule

// File: rtl/frx_frame_rx.sv
// Module: fixed-length frame receiver. Hunts for the four-byte marker, walks the
// header, data and CRC by byte index, and gives one verdict per frame.
// Assumes in_data is valid only with in_valid; fields are little-endian.
module frx_frame_rx
    import frx_pkg::*;
#(
    parameter int  PAYLOAD_BYTES = 256,
    localparam int AW            = $clog2(PAYLOAD_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          frame_done,
    output logic          frame_good,
    output logic          frame_crc_err,
    output logic          frame_malformed,
    output logic          frame_is_ping,
    output logic [31:0]   frame_seq,
    output logic [15:0]   frame_len,
    output logic [31:0]   lost_count,
    output logic          peer_reset,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int BODY_BYTES = 4 + 2 + 2 + PAYLOAD_BYTES + 4;
    localparam int IW         = $clog2(BODY_BYTES);
    localparam int MW         = $clog2(MARK_LEN);
    localparam logic [IW-1:0] I_VER  = IW'(4);
    localparam logic [IW-1:0] I_LEN  = IW'(6);
    localparam logic [IW-1:0] I_DATA = IW'(8);
    localparam logic [IW-1:0] I_CRC  = IW'(8 + PAYLOAD_BYTES);
    localparam logic [IW-1:0] I_LAST = IW'(BODY_BYTES - 1);
    localparam logic [MW-1:0] M_LAST = MW'(MARK_LEN - 1);

    rx_state_t     state;
    logic [MW-1:0] mark_cnt;
    logic [IW-1:0] idx;
    logic [31:0]   seq_sh;
    logic [15:0]   ver_sh;
    logic [15:0]   len_sh;
    logic [23:0]   crc_lo;
    logic [31:0]   crc_val;
    logic [IW-1:0] doff;

    logic take, mark_done, in_seq, in_ver, in_len, in_dat, in_crc, last;
    logic crc_ok, ver_ok, len_ok, good_now;

    // Decode which field the current byte belongs to.
    always_comb begin
        take      = in_valid && state == ST_BODY;
        mark_done = in_valid && state == ST_HUNT && in_data == MARK_BYTE && mark_cnt == M_LAST;
        in_seq    = take && idx < I_VER;
        in_ver    = take && idx >= I_VER && idx < I_LEN;
        in_len    = take && idx >= I_LEN && idx < I_DATA;
        in_dat    = take && idx >= I_DATA && idx < I_CRC;
        in_crc    = take && idx >= I_CRC;
        last      = take && idx == I_LAST;
        doff      = idx - I_DATA;
    end

    // Judge the frame on its final byte.
    always_comb begin
        crc_ok   = {in_data, crc_lo} == crc_val;
        ver_ok   = ver_sh == VER_DATA || ver_sh == VER_PING;
        len_ok   = len_sh <= 16'(PAYLOAD_BYTES);
        good_now = last && crc_ok && ver_ok && len_ok;
    end

    // Marker hunt and byte-index walk through the frame body.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HUNT;
            mark_cnt <= '0;
            idx      <= '0;
        end else if (state == ST_HUNT) begin
            if (mark_done) begin
                state    <= ST_BODY;
                mark_cnt <= '0;
                idx      <= '0;
            end else if (in_valid) begin
                mark_cnt <= (in_data == MARK_BYTE) ? mark_cnt + MW'(1) : '0;
            end
        end else if (in_valid) begin
            if (last) state <= ST_HUNT;
            idx <= idx + IW'(1);
        end
    end

    // Gather the little-endian header fields and the received CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_sh <= '0;
            ver_sh <= '0;
            len_sh <= '0;
            crc_lo <= '0;
        end else begin
            if (in_seq) seq_sh <= {in_data, seq_sh[31:8]};
            if (in_ver) ver_sh <= {in_data, ver_sh[15:8]};
            if (in_len) len_sh <= {in_data, len_sh[15:8]};
            if (in_crc) crc_lo <= {in_data, crc_lo[23:8]};
        end
    end

    // Register the verdict strobe and the fields of the finished frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_done      <= 1'b0;
            frame_good      <= 1'b0;
            frame_crc_err   <= 1'b0;
            frame_malformed <= 1'b0;
            frame_is_ping   <= 1'b0;
            frame_seq       <= '0;
            frame_len       <= '0;
        end else begin
            frame_done      <= last;
            frame_good      <= good_now;
            frame_crc_err   <= last && !crc_ok;
            frame_malformed <= last && crc_ok && !(ver_ok && len_ok);
            if (last) begin
                frame_is_ping <= ver_sh == VER_PING;
                frame_seq     <= seq_sh;
                frame_len     <= len_sh;
            end
        end
    end

    frx_crc32 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (mark_done),
        .feed  (in_seq || in_len || in_dat),
        .data  (in_data),
        .crc   (crc_val)
    );

    frx_payload_buf #(.DEPTH(PAYLOAD_BYTES)) u_buf (
        .clk   (clk),
        .we    (in_dat),
        .waddr (doff[AW-1:0]),
        .wdata (in_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    frx_seq_track #(.SEQ_W(32)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (good_now),
        .seq_in     (seq_sh),
        .lost_count (lost_count),
        .peer_reset (peer_reset)
    );

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $countones({frame_good, frame_crc_err, frame_malformed}) == 1); // R5
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> !(frame_good || frame_crc_err || frame_malformed)); // R5
    AST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R5
    AST_BACK_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> state == ST_HUNT); // R12
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_BODY |-> idx <= I_LAST); // R3
    AST_LOSS_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        (lost_count != '0 || peer_reset) |-> frame_good); // R13
    AST_RESET_SEQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        peer_reset |-> frame_seq == '0); // R11
endmodule

// File: tb/frx_frame_rx_tb.sv
`timescale 1ns/1ps
module frx_frame_rx_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        frame_done, frame_good, frame_crc_err, frame_malformed, frame_is_ping, peer_reset;
    logic [31:0] frame_seq, lost_count;
    logic [15:0] frame_len;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] fb [272];
    logic [7:0] exp_pl [256];

    always #2 clk = ~clk;

    frx_frame_rx u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .frame_done(frame_done), .frame_good(frame_good), .frame_crc_err(frame_crc_err),
        .frame_malformed(frame_malformed), .frame_is_ping(frame_is_ping),
        .frame_seq(frame_seq), .frame_len(frame_len), .lost_count(lost_count),
        .peer_reset(peer_reset), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference CRC: XOR the byte into the top, then shift eight times.
    function automatic logic [31:0] ref_crc(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {b, 24'h0};
        for (int k = 0; k < 8; k++) r = r[31] ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
        return r;
    endfunction

    task automatic put_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
    endtask

    // Build and send one frame; returns at the falling edge where the verdict is due.
    task automatic send_frame(input logic [31:0] seq, input logic [15:0] ver,
                              input logic [15:0] len, input logic [7:0] seed,
                              input bit bad_crc, input bit stall);
        logic [31:0] c;
        for (int i = 0; i < 4; i++) fb[i] = 8'hAA;
        for (int i = 0; i < 4; i++) fb[4+i] = seq[8*i +: 8];
        fb[8] = ver[7:0];  fb[9]  = ver[15:8];
        fb[10] = len[7:0]; fb[11] = len[15:8];
        for (int i = 0; i < 256; i++) begin
            exp_pl[i] = (i < int'(len)) ? 8'(seed + 8'(i * 7)) : 8'h00;
            fb[12+i]  = exp_pl[i];
        end
        c = 32'hFFFFFFFF;
        for (int i = 4; i < 268; i++) if (i < 8 || i >= 10) c = ref_crc(c, fb[i]);
        if (bad_crc) c = c ^ 32'h0000_0100;
        for (int i = 0; i < 4; i++) fb[268+i] = c[8*i +: 8];
        for (int i = 0; i < 272; i++) begin
            put_byte(fb[i]);
            if (stall && (i % 17) == 5) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_res(input string req, input bit g, input bit ce, input bit m,
                              input bit p, input logic [31:0] s, input logic [15:0] l,
                              input logic [31:0] lost, input bit pr);
        chk({req, " done"}, 32'(frame_done), 32'd1);
        chk({req, " good"}, 32'(frame_good), 32'(g));
        chk({req, " crc_err"}, 32'(frame_crc_err), 32'(ce));
        chk({req, " malformed"}, 32'(frame_malformed), 32'(m));
        chk({req, " seq"}, frame_seq, s);
        chk({req, " len"}, 32'(frame_len), 32'(l));
        chk({req, " ping"}, 32'(frame_is_ping), 32'(p));
        chk({req, " lost"}, lost_count, lost);
        chk({req, " peer_reset"}, 32'(peer_reset), 32'(pr));
        @(negedge clk);
        chk("R5 single-cycle strobe", 32'(frame_done), 32'd0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] s;
        logic [31:0] base;
        int dif;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 done", 32'(frame_done), 0);
        chk("R1 flags", 32'({frame_good, frame_crc_err, frame_malformed, peer_reset}), 0);
        chk("R1 seq", frame_seq, 0);
        chk("R1 lost", lost_count, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'(frame_done), 0);

        // R9 R3 R4: first good frame sets the baseline, little-endian fields
        base = 32'h00A1_0005;
        send_frame(base, 16'h0001, 16'h00F3, 8'h31, 0, 0);
        expect_res("R9 R3 R4 first", 1, 0, 0, 0, base, 16'h00F3, 0, 0);
        // R8: data area read back, including the zero padding
        for (int i = 0; i < 256; i++) begin
            rd_addr = 8'(i);
            #0.1;
            chk("R8 payload", 32'(rd_data), 32'(exp_pl[i]));
        end

        // R6 R12: ping frame with stalls, full length
        send_frame(base + 1, 16'h0002, 16'h0100, 8'h07, 0, 1);
        expect_res("R6 R12 ping stalled", 1, 0, 0, 1, base + 1, 16'h0100, 0, 0);

        // R10: gap of two frames
        send_frame(base + 4, 16'h0001, 16'd20, 8'h55, 0, 0);
        expect_res("R10 gap", 1, 0, 0, 0, base + 4, 16'd20, 2, 0);

        // R4: CRC error verdict
        send_frame(base + 40, 16'h0001, 16'd20, 8'h55, 1, 0);
        expect_res("R4 crc error", 0, 1, 0, 0, base + 40, 16'd20, 0, 0);

        // R2: partial markers and stray bytes give no verdict
        put_byte(8'hAA); put_byte(8'hAA); put_byte(8'hAA); put_byte(8'h11);
        put_byte(8'hAA); put_byte(8'hAA); put_byte(8'h55); put_byte(8'h00);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 no verdict on noise", 32'(frame_done), 0);
        put_byte(8'hAA); put_byte(8'hAA); put_byte(8'h3C);
        // R13: baseline still base+4 after the CRC error
        send_frame(base + 5, 16'h0001, 16'd1, 8'h99, 0, 0);
        expect_res("R2 R13 resync", 1, 0, 0, 0, base + 5, 16'd1, 0, 0);

        // R7: unknown version and excess length with good CRC
        send_frame(base + 9, 16'h0007, 16'd8, 8'h10, 0, 0);
        expect_res("R7 bad version", 0, 0, 1, 0, base + 9, 16'd8, 0, 0);
        send_frame(base + 9, 16'h0001, 16'd300, 8'h10, 0, 0);
        expect_res("R7 bad length", 0, 0, 1, 0, base + 9, 16'd300, 0, 0);
        send_frame(base + 6, 16'h0001, 16'd256, 8'h20, 0, 0);
        expect_res("R13 baseline kept", 1, 0, 0, 0, base + 6, 16'd256, 0, 0);

        // R10: sweep of gap sizes
        s = base + 6;
        for (int k = 1; k <= 5; k++) begin
            s = s + 32'(k);
            dif = k - 1;
            send_frame(s, (k % 2) ? 16'h0001 : 16'h0002, 16'(k * 11), 8'(k), 0, 0);
            expect_res("R10 sweep", 1, 0, 0, (k % 2) == 0, s, 16'(k * 11), 32'(dif), 0);
        end

        // R11: fall back to zero
        send_frame(32'd0, 16'h0001, 16'd4, 8'h42, 0, 0);
        expect_res("R11 peer reset", 1, 0, 0, 0, 0, 16'd4, 0, 1);
        send_frame(32'd3, 16'h0001, 16'd4, 8'h42, 0, 0);
        expect_res("R10 after restart", 1, 0, 0, 0, 3, 16'd4, 2, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule